// File: doc/BRIEF.md
# Mirrored Filter Coefficient Expander

This block keeps the coefficients of a linear-phase scaler filter in a compact, half-stored form and plays the full 32-tap kernel back, one signed tap per cycle, to a polyphase scaler stage. Each 32-bit kernel word carries three 9-bit two's-complement coefficients. Only the first six words are unique. The other five are the first five in reverse word order, read with their in-word order reversed. The last slot of the sixth word is a pad and is never emitted.

Software loads the unique words through a simple write port. A single-cycle start pulse then launches one pass. The block steps through the logical 11-word kernel, skips the pad slot, sign-extends every field and presents the taps on a valid/ready stream. A last flag marks the final tap. A `MIRROR_LOAD` parameter selects what is stored. When set, only the six unique words are kept and the mirrored half is produced by address folding. When clear, all eleven words are stored and read in order.

Top module: `mirror_tap_expander`

## Requirements
- R1: After reset `tap_valid` is low and stays low until a start pulse is sampled.
- R2: Field slot j of a word (j = 0, 1, 2) is taken from bits [9j+8:9j] and emitted sign-extended to 12 bits. Bits 31:27 of a word have no effect on any tap.
- R3: Tap k for k = 0..16 comes from word k/3, slot k mod 3. Tap k for k = 17..31 comes from word 6 + (k−17)/3, slot 2 − (k−17) mod 3. For a symmetric kernel with unique coefficients c0..c15, tap k equals c(k) for k < 16 and c(31−k) otherwise.
- R4: With the default mirrored storage, logical word i ≥ 6 is read from stored word 10 − i. Writes to addresses 6 to 15 are ignored.
- R5: The pad slot (word 5, bits 26:18) is never emitted, and its contents do not affect the taps.
- R6: A start pulse sampled while idle makes the first tap valid on the next cycle. Exactly 32 taps follow, `tap_last` is high only on tap 31, and `tap_valid` falls in the cycle after tap 31 is accepted.
- R7: While `tap_valid` is high and `tap_ready` is low, the tap value, the last flag and the position in the kernel hold.
- R8: A start pulse received while a pass is streaming is ignored, including one in the cycle of the final handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Kernel word write strobe |
| wr_addr | input | 4 | Kernel word address |
| wr_data | input | 32 | Kernel word (three 9-bit fields) |
| start | input | 1 | Pulse that launches one 32-tap pass |
| tap_valid | output | 1 | Tap on `tap_data` is valid |
| tap_ready | input | 1 | Consumer accepts the current tap |
| tap_data | output | 12 | Sign-extended tap coefficient |
| tap_last | output | 1 | Marks tap 31 of the pass |

## Verification
The first tap of a pass is due one clock after the rising edge that samples the start pulse. Each later tap is due one clock after the edge where the previous tap was accepted. `tap_valid` drops one clock after the edge that accepts tap 31. The bench updates a behavioural model on each rising edge from the inputs it drove half a period earlier. It compares `tap_valid`, `tap_data` and `tap_last` with the model on every falling edge, so each expected value is checked in the cycle it is due. Passes are run with ready held high, with random back-pressure, with extreme and pad-polluted kernels, after ignored writes, and with stray start pulses.

// File: rtl/mfce_pkg.sv
package mfce_pkg;
   localparam int unsigned DEF_WORD_W     = 32;
   localparam int unsigned DEF_COEF_W     = 9;
   localparam int unsigned DEF_SLOTS      = 3;
   localparam int unsigned DEF_HALF_WORDS = 6;
   localparam int unsigned DEF_OUT_W      = 12;

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_state_e;

   function automatic int unsigned kernel_words(input int unsigned half_words);
      return 2 * half_words - 1;
   endfunction

   function automatic int unsigned tap_count(input int unsigned half_words,
                                             input int unsigned slots);
      return slots * kernel_words(half_words) - 1;
   endfunction
endpackage

// File: rtl/tap_kernel_store.sv
module tap_kernel_store #(
   parameter int unsigned WORD_W     = mfce_pkg::DEF_WORD_W,
   parameter int unsigned HALF_WORDS = mfce_pkg::DEF_HALF_WORDS,
   parameter int unsigned ADDR_W     = 4,
   parameter bit          MIRROR     = 1'b1,
   localparam int unsigned KW        = mfce_pkg::kernel_words(HALF_WORDS),
   localparam int unsigned WIDX_W    = $clog2(KW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [WIDX_W-1:0] rd_idx,
   output logic [WORD_W-1:0] rd_word
);
   localparam int unsigned DEPTH = MIRROR ? HALF_WORDS : KW;
   localparam int unsigned MI_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (ADDR_W < WIDX_W) begin : g_bad_addr
         $error("tap_kernel_store: ADDR_W too narrow for the kernel");
      end
   endgenerate

   logic [WORD_W-1:0] mem_q [DEPTH];
   logic [WIDX_W-1:0] phys_idx;
   logic              wr_hit;

   // Address folding variant is chosen by parameter.
   generate
      if (MIRROR) begin : g_fold
         always_comb begin
            if (int'(rd_idx) < int'(HALF_WORDS))
               phys_idx = rd_idx;
            else
               phys_idx = WIDX_W'(KW - 1) - rd_idx;
         end
      end else begin : g_flat
         always_comb phys_idx = rd_idx;
      end
   endgenerate

   assign wr_hit  = wr_en && (int'(wr_addr) < int'(DEPTH));
   assign rd_word = mem_q[phys_idx[MI_W-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      end else if (wr_hit) begin
         mem_q[wr_addr[MI_W-1:0]] <= wr_data;
      end
   end

   // R4: the folded read address always lands inside the stored words
   assert_phys_in_range_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      int'(rd_idx) < int'(KW) |-> int'(phys_idx) < int'(DEPTH));
endmodule

// File: rtl/tap_walk_seq.sv
module tap_walk_seq #(
   parameter int unsigned HALF_WORDS = mfce_pkg::DEF_HALF_WORDS,
   parameter int unsigned SLOTS      = mfce_pkg::DEF_SLOTS,
   localparam int unsigned KW        = mfce_pkg::kernel_words(HALF_WORDS),
   localparam int unsigned WIDX_W    = $clog2(KW),
   localparam int unsigned SLOT_W    = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ready,
   output logic              busy,
   output logic [WIDX_W-1:0] word_idx,
   output logic [SLOT_W-1:0] slot_idx,
   output logic              last
);
   import mfce_pkg::*;

   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("tap_walk_seq: at least two slots per word are required");
      end
      if (HALF_WORDS < 2) begin : g_bad_half
         $error("tap_walk_seq: at least two unique words are required");
      end
   endgenerate

   localparam logic [SLOT_W-1:0] S_TOP  = SLOT_W'(SLOTS - 1);
   localparam logic [SLOT_W-1:0] S_PRE  = SLOT_W'(SLOTS - 2);
   localparam logic [WIDX_W-1:0] W_MID  = WIDX_W'(HALF_WORDS - 1);
   localparam logic [WIDX_W-1:0] W_END  = WIDX_W'(KW - 1);

   walk_state_e       st_q, st_d;
   logic [WIDX_W-1:0] w_q, w_d;
   logic [SLOT_W-1:0] s_q, s_d;
   logic              upper;

   assign upper    = (w_q > W_MID);
   assign busy     = (st_q == WALK_RUN);
   assign word_idx = w_q;
   assign slot_idx = s_q;
   assign last     = busy && (w_q == W_END) && (s_q == '0);

   always_comb begin
      st_d = st_q;
      w_d  = w_q;
      s_d  = s_q;
      if (st_q == WALK_IDLE) begin
         if (start) begin
            st_d = WALK_RUN;
            w_d  = '0;
            s_d  = '0;
         end
      end else if (ready) begin
         if (last) begin
            st_d = WALK_IDLE;
         end else if (!upper) begin
            if ((w_q == W_MID) && (s_q == S_PRE)) begin
               // step over the pad slot into the mirrored half
               w_d = w_q + 1'b1;
               s_d = S_TOP;
            end else if (s_q == S_TOP) begin
               w_d = w_q + 1'b1;
               s_d = '0;
            end else begin
               s_d = s_q + 1'b1;
            end
         end else begin
            if (s_q == '0) begin
               w_d = w_q + 1'b1;
               s_d = S_TOP;
            end else begin
               s_d = s_q - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= WALK_IDLE;
         w_q  <= '0;
         s_q  <= '0;
      end else begin
         st_q <= st_d;
         w_q  <= w_d;
         s_q  <= s_d;
      end
   end

   // R5: the pad position is never presented
   assert_no_pad_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !((w_q == W_MID) && (s_q == S_TOP)));

   // R3: the mirrored half walks slots downward
   assert_upper_descends_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      busy && ready && upper && (s_q != '0) |=> busy && (s_q == $past(s_q) - 1'b1));

   // R6: a pass always starts at the first word and slot
   assert_start_origin_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start |=> busy && (w_q == '0) && (s_q == '0));
endmodule

// File: rtl/tap_field_unpack.sv
module tap_field_unpack #(
   parameter int unsigned WORD_W = mfce_pkg::DEF_WORD_W,
   parameter int unsigned COEF_W = mfce_pkg::DEF_COEF_W,
   parameter int unsigned SLOTS  = mfce_pkg::DEF_SLOTS,
   parameter int unsigned OUT_W  = mfce_pkg::DEF_OUT_W,
   localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic [SLOT_W-1:0] slot,
   output logic [OUT_W-1:0]  tap
);
   generate
      if (SLOTS * COEF_W > WORD_W) begin : g_bad_pack
         $error("tap_field_unpack: fields do not fit in a word");
      end
      if (OUT_W < COEF_W) begin : g_bad_out
         $error("tap_field_unpack: output narrower than a coefficient");
      end
   endgenerate

   logic [COEF_W-1:0] field [SLOTS];
   logic [COEF_W-1:0] picked;

   generate
      for (genvar g = 0; g < int'(SLOTS); g++) begin : g_field
         assign field[g] = word_in[g*COEF_W +: COEF_W];
      end
   endgenerate

   assign picked = field[slot];

   generate
      if (OUT_W > COEF_W) begin : g_extend
         assign tap = {{(OUT_W-COEF_W){picked[COEF_W-1]}}, picked};
      end else begin : g_exact
         assign tap = picked;
      end
   endgenerate
endmodule

// File: rtl/mirror_tap_expander.sv
module mirror_tap_expander #(
   parameter int unsigned WORD_W     = mfce_pkg::DEF_WORD_W,
   parameter int unsigned COEF_W     = mfce_pkg::DEF_COEF_W,
   parameter int unsigned SLOTS      = mfce_pkg::DEF_SLOTS,
   parameter int unsigned HALF_WORDS = mfce_pkg::DEF_HALF_WORDS,
   parameter int unsigned OUT_W      = mfce_pkg::DEF_OUT_W,
   parameter int unsigned ADDR_W     = 4,
   parameter bit          MIRROR_LOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              start,
   output logic              tap_valid,
   input  logic              tap_ready,
   output logic [OUT_W-1:0]  tap_data,
   output logic              tap_last
);
   localparam int unsigned KW     = mfce_pkg::kernel_words(HALF_WORDS);
   localparam int unsigned TAPS   = mfce_pkg::tap_count(HALF_WORDS, SLOTS);
   localparam int unsigned WIDX_W = $clog2(KW);
   localparam int unsigned SLOT_W = $clog2(SLOTS);
   localparam int unsigned CNT_W  = $clog2(TAPS) + 1;

   logic [WIDX_W-1:0] word_idx;
   logic [SLOT_W-1:0] slot_idx;
   logic [WORD_W-1:0] cur_word;

   tap_walk_seq #(
      .HALF_WORDS (HALF_WORDS),
      .SLOTS      (SLOTS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ready    (tap_ready),
      .busy     (tap_valid),
      .word_idx (word_idx),
      .slot_idx (slot_idx),
      .last     (tap_last)
   );

   tap_kernel_store #(
      .WORD_W     (WORD_W),
      .HALF_WORDS (HALF_WORDS),
      .ADDR_W     (ADDR_W),
      .MIRROR     (MIRROR_LOAD)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_idx  (word_idx),
      .rd_word (cur_word)
   );

   tap_field_unpack #(
      .WORD_W (WORD_W),
      .COEF_W (COEF_W),
      .SLOTS  (SLOTS),
      .OUT_W  (OUT_W)
   ) u_unpack (
      .word_in (cur_word),
      .slot    (slot_idx),
      .tap     (tap_data)
   );

   // Handshake counter used only by the pass-length checks below.
   logic [CNT_W-1:0] acc_cnt_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_cnt_q <= '0;
      else if (!tap_valid)
         acc_cnt_q <= '0;
      else if (tap_ready)
         acc_cnt_q <= acc_cnt_q + 1'b1;
   end

   assert_last_on_final_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      tap_valid && tap_last |-> acc_cnt_q == CNT_W'(TAPS - 1));

   assert_no_early_last_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      tap_valid && !tap_last |-> acc_cnt_q < CNT_W'(TAPS - 1));

   assert_valid_drops_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      tap_valid && tap_ready && tap_last |=> !tap_valid);

   assert_hold_stall_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      tap_valid && !tap_ready && !wr_en |=>
         tap_valid && $stable(tap_data) && $stable(tap_last));

   assert_start_ignored_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      tap_valid && start && !tap_ready |=>
         tap_valid && $stable(word_idx) && $stable(slot_idx));

   assert_idle_quiet_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !tap_valid && !start |=> !tap_valid);
endmodule

// File: tb/mirror_tap_expander_test.sv
module mirror_tap_expander_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        start = 1'b0;
   logic        tap_ready = 1'b0;
   logic        tap_valid;
   logic [11:0] tap_data;
   logic        tap_last;

   always #2 clk = ~clk;

   mirror_tap_expander uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start(start), .tap_valid(tap_valid),
      .tap_ready(tap_ready), .tap_data(tap_data), .tap_last(tap_last)
   );

   int    errors = 0;
   int    checks = 0;
   int    exp_tap [32];
   bit    m_busy = 0;
   int    m_idx = 0;
   bit    cmp_on = 0;
   string req = "R1";
   int    cyc = 0;

   // behavioural model, advanced on the rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_idx = 0;
      end else if (!m_busy) begin
         if (start) begin m_busy = 1; m_idx = 0; end
      end else if (tap_ready) begin
         if (m_idx == 31) m_busy = 0;
         else m_idx++;
      end
      if (cyc > 100000) begin
         errors++; checks++;
         $display("FAIL R6 watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // comparison on every falling edge
   always @(negedge clk) begin
      if (cmp_on) begin
         checks++;
         if (tap_valid !== m_busy) begin
            errors++;
            $display("FAIL %s valid actual=%0b expected=%0b", req, tap_valid, m_busy);
         end
         if (m_busy) begin
            checks += 2;
            if ($signed(tap_data) != exp_tap[m_idx]) begin
               errors++;
               $display("FAIL %s tap%0d actual=%0d expected=%0d", req, m_idx,
                        $signed(tap_data), exp_tap[m_idx]);
            end
            if (tap_last !== (m_idx == 31)) begin
               errors++;
               $display("FAIL R6 last at tap%0d actual=%0b expected=%0b", m_idx,
                        tap_last, (m_idx == 31));
            end
         end
      end
   end

   function automatic logic [31:0] pack(int a, int b, int c, logic [4:0] top);
      return {top, 9'(c), 9'(b), 9'(a)};
   endfunction

   task automatic wr(int addr, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(addr); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // loads the six unique words; expected taps follow R3 symmetry
   task automatic load(input int c [16], input int pad, input logic [4:0] top);
      for (int w = 0; w < 5; w++) wr(w, pack(c[3*w], c[3*w+1], c[3*w+2], top));
      wr(5, pack(c[15], c[15], pad, top));
      for (int k = 0; k < 32; k++) exp_tap[k] = (k < 16) ? c[k] : c[31-k];
   endtask

   // mode 0: ready high; 1: random ready; 2: random ready plus stray starts
   task automatic run_pass(int mode);
      @(negedge clk);
      start = 1'b1;
      tap_ready = (mode == 0) ? 1'b1 : 1'($urandom % 2);
      @(negedge clk);
      start = 1'b0;
      forever begin
         if (!m_busy) break;
         tap_ready = (mode == 0) ? 1'b1 : 1'($urandom % 2);
         start = (mode == 2) ? 1'($urandom % 2) : 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      tap_ready = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int mn [16];
      int ex [16];
      mn = '{0, -2, -6, -8, -10, -8, -3, 2, 18, 50, 82, 119, 155, 187, 213, 227};
      ex = '{-256, 255, -1, 1, -255, 254, 0, -128, 127, -2, 2, 100, -100, 200, -200, -256};
      for (int k = 0; k < 32; k++) exp_tap[k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (tap_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 valid after reset actual=%0b expected=0", tap_valid);
      end
      cmp_on = 1;
      req = "R1";
      repeat (5) @(negedge clk);

      req = "R3";
      load(mn, 0, 5'd0);
      run_pass(0);

      req = "R7";
      run_pass(1);
      run_pass(1);

      req = "R2";
      load(ex, 9'h155, 5'b10101);
      run_pass(0);

      req = "R5";
      load(ex, 9'h0AB, 5'b01010);
      run_pass(1);

      req = "R4";
      for (int a = 6; a < 16; a++) wr(a, 32'hDEAD_BEEF ^ 32'(a));
      run_pass(0);
      run_pass(1);

      req = "R8";
      load(mn, 9'h1FF, 5'b11111);
      run_pass(2);
      run_pass(2);
      run_pass(2);

      req = "R6";
      run_pass(0);

      cmp_on = 0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule